// File: doc/BRIEF.md
# 4x4 Unsigned Multiplier with Column Compressors

This block multiplies two unsigned 4-bit operands and delivers an 8-bit product. It first builds four 8-bit partial-product rows. Row i holds the multiplicand shifted left by i places when bit i of the multiplier is set, and holds zero when that bit is clear. A reduction network then sums the sixteen partial-product bits one column at a time.

The reduction uses a 4-input bit-counting compressor made of half adders. The compressor adds two pairs of its inputs, adds the two pair sums, and merges the three carries into a weight-2 output and a weight-4 output. The first layer of compressors takes the raw column bits. A second layer folds each column's sum together with the carries that arrive from one and two columns below. A final rippling layer resolves the remaining two rows into the product. An output register, selected by a parameter and enabled by default, holds the product. It has a synchronous active-high reset.

Top module: `mulc_top`

## Requirements
- R1: With the output register enabled, `prod_o` equals the unsigned product `mplier_i * mcand_i` sampled at the previous rising edge, for all 256 operand pairs.
- R2: Partial-product row i is zero when multiplier bit i is 0. Otherwise it is the multiplicand placed at bits i..i+3, with zeros in every other bit.
- R3: Each compressor reports its input count exactly: sum + 2*w2 + 4*w4 equals the number of ones among its four inputs. This includes the all-ones case, which gives w4=1, w2=0, sum=0.
- R4: Weight-2 carries move one column up and weight-4 carries move two columns up. The weighted value of the first and second compressor layers equals the sum of the partial-product rows, which equals the product.
- R5: The second and ripple layers never raise a weight-4 carry, and no carry leaves the top column.
- R6: A rising edge with `rst` high makes `prod_o` read 0 whatever the operand values are.
- R7: `prod_o` changes only at a rising edge. When both operands stay unchanged, `prod_o` stays unchanged.
- R8: A zero operand on either side gives a zero product, and 15 x 15 gives 225.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset; clears the product |
| mplier_i | input | 4 | Multiplier operand; bit i selects partial-product row i |
| mcand_i | input | 4 | Multiplicand operand |
| prod_o | output | 8 | Unsigned product |

## Verification
Only one operand pair drives a compressor with all four inputs set. Column 3 needs every bit of both operands to be 1, so 15 x 15 is the single case that exercises the weight-4 path of R3. The bench applies that pair on its own as a directed step, then covers it again during the full sweep of all 256 pairs. Holding the operands steady across several edges, and changing them just before an edge, shows that the output moves only on a clock edge.

// File: rtl/mulc_pkg.sv
package mulc_pkg;

    localparam int unsigned OPW   = 4;
    localparam int unsigned PRODW = 2 * OPW;
    localparam int unsigned NCOL  = PRODW;
    localparam int unsigned CMPW  = 4;

    typedef logic [OPW-1:0]   opnd_t;
    typedef logic [PRODW-1:0] prod_t;
    typedef prod_t [OPW-1:0]  pp_arr_t;

    typedef struct packed {
        logic s;
        logic c;
    } ha_t;

    typedef struct packed {
        logic sum;
        logic w2;
        logic w4;
    } cmp_out_t;

    function automatic ha_t half_add(input logic x, input logic y);
        ha_t r;
        r.s = x ^ y;
        r.c = x & y;
        return r;
    endfunction

    function automatic logic [CMPW-1:0] col_bits(input pp_arr_t pp, input int unsigned col);
        logic [CMPW-1:0] v;
        v = '0;
        for (int i = 0; i < OPW; i++) begin
            v[i] = pp[i][col];
        end
        return v;
    endfunction

endpackage

// File: rtl/mulc_cmp4.sv
module mulc_cmp4
    import mulc_pkg::*;
(
    input  logic [CMPW-1:0] bits_i,
    output cmp_out_t        res_o
);

    ha_t lo_h;
    ha_t hi_h;
    ha_t mid_h;
    ha_t cy_h;

    always_comb begin
        lo_h  = half_add(bits_i[0], bits_i[1]);
        hi_h  = half_add(bits_i[2], bits_i[3]);
        mid_h = half_add(lo_h.s, hi_h.s);
        // pair carries and the middle carry: mid_h.c excludes lo_h.c/hi_h.c
        cy_h  = half_add(lo_h.c, hi_h.c);
        res_o.sum = mid_h.s;
        res_o.w2  = cy_h.s | mid_h.c;
        res_o.w4  = cy_h.c;
    end

endmodule

// File: rtl/mulc_ppgen.sv
module mulc_ppgen
    import mulc_pkg::*;
(
    input  opnd_t   mplier_i,
    input  opnd_t   mcand_i,
    output pp_arr_t pp_o
);

    always_comb begin
        for (int i = 0; i < OPW; i++) begin
            pp_o[i] = '0;
            if (mplier_i[i]) begin
                pp_o[i][i +: OPW] = mcand_i;
            end
        end
    end

endmodule

// File: rtl/mulc_reduce.sv
module mulc_reduce
    import mulc_pkg::*;
(
    input  pp_arr_t pp_i,
    output prod_t   sum_o
);

    cmp_out_t [NCOL-1:0] st1_w;
    cmp_out_t [NCOL-1:0] st2_w;
    cmp_out_t [NCOL-1:0] st3_w;
    logic     [NCOL:0]   rip_w;
    logic                dropped_unused;

    assign rip_w[0] = 1'b0;

    for (genvar k = 0; k < NCOL; k++) begin : g_col
        logic [CMPW-1:0] in1;
        logic [CMPW-1:0] in2;
        logic [CMPW-1:0] in3;
        logic            up2;
        logic            up4;
        logic            prv2;

        assign in1 = col_bits(pp_i, k);

        if (k >= 1) begin : g_from1
            assign up2  = st1_w[k-1].w2;
            assign prv2 = st2_w[k-1].w2;
        end else begin : g_from1_none
            assign up2  = 1'b0;
            assign prv2 = 1'b0;
        end

        if (k >= 2) begin : g_from2
            assign up4 = st1_w[k-2].w4;
        end else begin : g_from2_none
            assign up4 = 1'b0;
        end

        assign in2 = {1'b0, up4, up2, st1_w[k].sum};
        assign in3 = {1'b0, rip_w[k], prv2, st2_w[k].sum};

        mulc_cmp4 u_lay1 (.bits_i(in1), .res_o(st1_w[k]));
        mulc_cmp4 u_lay2 (.bits_i(in2), .res_o(st2_w[k]));
        mulc_cmp4 u_lay3 (.bits_i(in3), .res_o(st3_w[k]));

        assign rip_w[k+1] = st3_w[k].w2;
        assign sum_o[k]   = st3_w[k].sum;
    end

    // carries that cannot be set for an in-range product
    always_comb begin
        dropped_unused = rip_w[NCOL] | st2_w[NCOL-1].w2 | st1_w[NCOL-1].w2
                       | st1_w[NCOL-1].w4 | st1_w[NCOL-2].w4;
        for (int k = 0; k < NCOL; k++) begin
            dropped_unused = dropped_unused | st2_w[k].w4 | st3_w[k].w4;
        end
    end

endmodule

// File: rtl/mulc_top.sv
module mulc_top
    import mulc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPW-1:0]   mplier_i,
    input  logic [OPW-1:0]   mcand_i,
    output logic [PRODW-1:0] prod_o
);

    pp_arr_t pp_w;
    prod_t   comb_prod;

    mulc_ppgen u_ppg (
        .mplier_i (mplier_i),
        .mcand_i  (mcand_i),
        .pp_o     (pp_w)
    );

    mulc_reduce u_red (
        .pp_i  (pp_w),
        .sum_o (comb_prod)
    );

    if (REG_OUT) begin : g_reg
        prod_t prod_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q <= '0;
            end else begin
                prod_q <= comb_prod;
            end
        end
        assign prod_o = prod_q;
    end else begin : g_comb
        assign prod_o = comb_prod;
    end

endmodule

// File: rtl/mulc_top_chk.sv
module mulc_top_chk
    import mulc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic [OPW-1:0]      mplier_i,
    input logic [OPW-1:0]      mcand_i,
    input logic [PRODW-1:0]    prod_o,
    input pp_arr_t             pp_w,
    input cmp_out_t [NCOL-1:0] st1_w,
    input cmp_out_t [NCOL-1:0] st2_w,
    input cmp_out_t [NCOL-1:0] st3_w,
    input logic [NCOL:0]       rip_w
);

    logic pp_ok;
    logic cnt_ok;
    logic val_ok;
    logic late_ok;
    logic rst_q = 1'b0;

    always_comb begin
        pp_ok = 1'b1;
        for (int i = 0; i < OPW; i++) begin
            if (!mplier_i[i] && pp_w[i] != '0) pp_ok = 1'b0;
            if ((pp_w[i] & ~(prod_t'({OPW{1'b1}}) << i)) != '0) pp_ok = 1'b0;
            if (mplier_i[i] && (pp_w[i] >> i) != prod_t'(mcand_i)) pp_ok = 1'b0;
        end
    end

    always_comb begin
        cnt_ok = 1'b1;
        for (int k = 0; k < NCOL; k++) begin
            int ones;
            ones = 0;
            for (int i = 0; i < OPW; i++) ones += int'(pp_w[i][k]);
            if (int'(st1_w[k].sum) + 2 * int'(st1_w[k].w2) + 4 * int'(st1_w[k].w4) != ones)
                cnt_ok = 1'b0;
        end
    end

    always_comb begin
        int v_pp;
        int v1;
        int v2;
        v_pp = 0;
        v1   = 0;
        v2   = 0;
        for (int i = 0; i < OPW; i++) v_pp += int'(pp_w[i]);
        for (int k = 0; k < NCOL; k++) begin
            v1 += (int'(st1_w[k].sum) + 2 * int'(st1_w[k].w2) + 4 * int'(st1_w[k].w4)) << k;
            v2 += (int'(st2_w[k].sum) + 2 * int'(st2_w[k].w2) + 4 * int'(st2_w[k].w4)) << k;
        end
        val_ok = (v1 == v_pp) && (v2 == v_pp) && (v_pp == int'(mplier_i) * int'(mcand_i));
    end

    always_comb begin
        late_ok = !rip_w[NCOL];
        for (int k = 0; k < NCOL; k++) begin
            if (st2_w[k].w4 || st3_w[k].w4) late_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) rst_q <= rst;

    assert_pp_rows_R2: assert property (@(posedge clk) disable iff (rst) pp_ok);
    assert_cmp_count_R3: assert property (@(posedge clk) disable iff (rst) cnt_ok);
    assert_carry_route_R4: assert property (@(posedge clk) disable iff (rst) val_ok);
    assert_no_late_w4_R5: assert property (@(posedge clk) disable iff (rst) late_ok);

    if (REG_OUT) begin : g_reg_chk
        assert_product_R1: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> prod_o == PRODW'($past(mplier_i)) * PRODW'($past(mcand_i)));

        assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
            ($stable(mplier_i) && $stable(mcand_i) && !$past(rst)) |=> $stable(prod_o));

        always @(posedge clk) begin
            if (rst_q) begin
                assert_reset_zero_R6: assert (prod_o == '0);
            end
        end
    end else begin : g_comb_chk
        assert_product_R1: assert property (@(posedge clk) disable iff (rst)
            prod_o == PRODW'(mplier_i) * PRODW'(mcand_i));
    end

endmodule

bind mulc_top mulc_top_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mplier_i (mplier_i),
    .mcand_i  (mcand_i),
    .prod_o   (prod_o),
    .pp_w     (pp_w),
    .st1_w    (u_red.st1_w),
    .st2_w    (u_red.st2_w),
    .st3_w    (u_red.st3_w),
    .rip_w    (u_red.rip_w)
);

// File: tb/mulc_top_bench.sv
module mulc_top_bench;

    typedef struct {
        logic [3:0] a;
        logic [3:0] b;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mplier = '0;
    logic [3:0] mcand  = '0;
    logic [7:0] prod;

    int    checks = 0;
    int    errors = 0;
    item_t sb[$];

    always #4 clk = ~clk;

    mulc_top u_mulc_top (
        .clk      (clk),
        .rst      (rst),
        .mplier_i (mplier),
        .mcand_i  (mcand),
        .prod_o   (prod)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d got=%0d exp=%0d", tag, mplier, mcand, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] a, input logic [3:0] b, input string tag);
        item_t it;
        @(negedge clk);
        mplier = a;
        mcand  = b;
        it.a = a;
        it.b = b;
        it.exp = 8'(a) * 8'(b);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    // monitor: result of the pair driven before edge appears after it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() != 0) begin
                item_t it;
                it = sb.pop_front();
                chk(it.tag, prod, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got=hang exp=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R6: reset state, then reset dominating non-zero operands
        repeat (3) @(posedge clk);
        #2;
        chk("R6 reset state", prod, 8'd0);
        @(negedge clk);
        mplier = 4'd15;
        mcand  = 4'd15;
        @(posedge clk);
        #2;
        chk("R6 reset with operands", prod, 8'd0);
        @(negedge clk);
        rst = 1'b0;

        // R8: zero operands and the largest product
        drive(4'd0, 4'd9, "R8 zero multiplier");
        drive(4'd7, 4'd0, "R8 zero multiplicand");
        // R3: only pair with four ones in one column
        drive(4'd15, 4'd15, "R3 all-ones column");
        // R2: single row selected, multiplicand placed at bit i
        drive(4'd1, 4'd15, "R2 row0");
        drive(4'd2, 4'd15, "R2 row1");
        drive(4'd4, 4'd15, "R2 row2");
        drive(4'd8, 4'd15, "R2 row3");
        // R4: carries routed one and two columns up
        drive(4'd13, 4'd11, "R4 carry routing");
        drive(4'd11, 4'd13, "R4 carry routing swapped");
        drive(4'd14, 4'd7, "R4 carry routing 14x7");
        // R5: top columns near full, no spill
        drive(4'd15, 4'd14, "R5 high product");
        drive(4'd15, 4'd15, "R8 max product");

        // R1: exhaustive sweep
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive(4'(i), 4'(j), "R1 sweep");
            end
        end
        drain();

        // R7: hold with steady operands, no change before an edge
        drive(4'd9, 4'd12, "R7 load");
        drain();
        for (int n = 0; n < 3; n++) begin
            @(posedge clk);
            #2;
            chk("R7 steady hold", prod, 8'd108);
        end
        @(negedge clk);
        mplier = 4'd3;
        mcand  = 4'd5;
        #1;
        chk("R7 no change before edge", prod, 8'd108);
        @(posedge clk);
        #2;
        chk("R7 update at edge", prod, 8'd15);

        // R6: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R6 mid-run reset", prod, 8'd0);
        @(negedge clk);
        rst = 1'b0;
        drive(4'd6, 4'd10, "R1 after reset");
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule